// File: doc/BRIEF.md
# Zero-Page Auto-Index Pointer Unit

This unit resolves the index operand of an extended memory-to-memory instruction. The operand names a byte in the first 256 bytes of memory, and that byte and the next one hold a 16-bit index pointer. When a request arrives, the unit fetches the pointer over a byte-wide synchronous memory port and returns the fetched value as the effective address. It then writes the pointer back after a post-modify step, or leaves it alone. The index byte address alone picks the step: one window of index locations steps forward by one, a second window steps back by one, and every other location is left unmodified.

An index address of zero means the instruction is not indexed. The unit then returns an effective address of zero and does not touch memory. Each request ends with a single-cycle done strobe, and the effective address is valid during that strobe. The block that decodes the instruction issues one request at a time and waits for done before issuing the next. The unit ignores any request made while it is busy.

Top module: `zp_auto_index`

## Requirements
- R1: While reset is asserted and after it is released, `done_o`, `busy_o`, `mem_re_o` and `mem_we_o` are all 0 until a request is accepted.
- R2: A request with index address 0x00 makes no memory read or write and completes with `ea_o` = 0x0000.
- R3: For any other index address A, the low pointer byte is read from address A and then the high byte from A+1, where A+1 wraps within 8 bits. `ea_o` at done is {high, low}, the value before any update.
- R4: For A in 0x02..0x3F, the pointer plus one, modulo 65536, is written back.
- R5: For A in 0x40..0x7F, the pointer minus one, modulo 65536, is written back.
- R6: For A = 0x01 or A in 0x80..0xFF, the unit makes no write, so memory stays unchanged.
- R7: The write-back puts the low byte at A first and the high byte at A+1 in the next cycle. `done_o` rises only after both writes, and it is high for exactly one cycle.
- R8: `start_i` is accepted only while `busy_o` is 0. A request made while busy produces no done strobe and no memory access at its own address.
- R9: A read strobe and a write strobe are never active in the same cycle.
- R10: Memory reads have a one-cycle latency: the data for a read issued in cycle n is sampled on `mem_rdata_i` in cycle n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken when not busy |
| idx_addr_i | input | 8 | Zero-page address of the index pointer |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion strobe |
| ea_o | output | 16 | Effective address, valid while done_o is 1 |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 8 | Zero-page byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, one cycle after the read strobe |

## Verification
The assertions assume three things about the environment. A request is meaningful only when `busy_o` is low. `idx_addr_i` needs to be stable only in the accept cycle. The memory returns read data exactly one cycle after a read strobe and handles no other traffic between a request and its done strobe. The bench memory model has a fixed one-cycle read latency and is the only agent on the port. The driver holds `start_i` for one cycle and waits for `busy_o` to fall before the next request. The one exception is a second strobe made on purpose while the unit is busy, which tests that it is ignored.

// File: rtl/zp_idx_pkg.sv
package zp_idx_pkg;

  typedef enum logic [1:0] {
    UPD_KEEP,
    UPD_INC,
    UPD_DEC,
    UPD_BYPASS
  } upd_mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_LO,
    S_RD_HI,
    S_CAP_HI,
    S_WR_LO,
    S_WR_HI,
    S_FIN
  } seq_state_e;

endpackage

// File: rtl/zp_range_classify.sv
module zp_range_classify
  import zp_idx_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned INC_LO = 2,
  parameter int unsigned INC_HI = 63,
  parameter int unsigned DEC_LO = 64,
  parameter int unsigned DEC_HI = 127
) (
  input  logic [ADDR_W-1:0] idx_i,
  output upd_mode_e         mode_o
);
  localparam logic [ADDR_W-1:0] INC_LO_C = ADDR_W'(INC_LO);
  localparam logic [ADDR_W-1:0] INC_HI_C = ADDR_W'(INC_HI);
  localparam logic [ADDR_W-1:0] DEC_LO_C = ADDR_W'(DEC_LO);
  localparam logic [ADDR_W-1:0] DEC_HI_C = ADDR_W'(DEC_HI);

  always_comb begin
    if (idx_i == '0)                                 mode_o = UPD_BYPASS;
    else if (idx_i >= INC_LO_C && idx_i <= INC_HI_C) mode_o = UPD_INC;
    else if (idx_i >= DEC_LO_C && idx_i <= DEC_HI_C) mode_o = UPD_DEC;
    else                                             mode_o = UPD_KEEP;
  end
endmodule

// File: rtl/zp_ptr_regs.sv
module zp_ptr_regs
  import zp_idx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              cap_lo_i,
  input  logic              cap_hi_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  upd_mode_e         mode_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [PTR_W-1:0]  nxt_o
);
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (clr_i) begin
      ptr_q <= '0;
    end else begin
      if (cap_lo_i) ptr_q[DATA_W-1:0]     <= rdata_i;
      if (cap_hi_i) ptr_q[PTR_W-1:DATA_W] <= rdata_i;
    end
  end

  // post-modify value, wraps naturally at PTR_W bits
  always_comb begin
    unique case (mode_i)
      UPD_INC: nxt_o = ptr_q + PTR_W'(1);
      UPD_DEC: nxt_o = ptr_q - PTR_W'(1);
      default: nxt_o = ptr_q;
    endcase
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/zp_seq_fsm.sv
module zp_seq_fsm
  import zp_idx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  upd_mode_e mode_new_i,
  input  upd_mode_e mode_i,
  output logic      accept_o,
  output logic      rd_o,
  output logic      wr_o,
  output logic      hi_sel_o,
  output logic      cap_lo_o,
  output logic      cap_hi_o,
  output logic      done_o,
  output logic      busy_o
);
  seq_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d  = state_q;
    accept_o = 1'b0;
    rd_o     = 1'b0;
    wr_o     = 1'b0;
    hi_sel_o = 1'b0;
    cap_lo_o = 1'b0;
    cap_hi_o = 1'b0;
    done_o   = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        accept_o = 1'b1;
        state_d  = (mode_new_i == UPD_BYPASS) ? S_FIN : S_RD_LO;
      end
      S_RD_LO: begin
        rd_o    = 1'b1;
        state_d = S_RD_HI;
      end
      S_RD_HI: begin
        rd_o     = 1'b1;
        hi_sel_o = 1'b1;
        cap_lo_o = 1'b1;   // low byte returns now
        state_d  = S_CAP_HI;
      end
      S_CAP_HI: begin
        cap_hi_o = 1'b1;
        state_d  = (mode_i == UPD_INC || mode_i == UPD_DEC) ? S_WR_LO : S_FIN;
      end
      S_WR_LO: begin
        wr_o    = 1'b1;
        state_d = S_WR_HI;
      end
      S_WR_HI: begin
        wr_o     = 1'b1;
        hi_sel_o = 1'b1;
        state_d  = S_FIN;
      end
      S_FIN: begin
        done_o  = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  assign busy_o = (state_q != S_IDLE);
endmodule

// File: rtl/zp_auto_index.sv
module zp_auto_index
  import zp_idx_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned INC_LO = 2,
  parameter int unsigned INC_HI = 63,
  parameter int unsigned DEC_LO = 64,
  parameter int unsigned DEC_HI = 127,
  localparam int unsigned PTR_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] idx_addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [PTR_W-1:0]  ea_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  upd_mode_e         mode_new, mode_q;
  logic [ADDR_W-1:0] idx_q;
  logic              accept, hi_sel, cap_lo, cap_hi;
  logic [PTR_W-1:0]  ptr, nxt;

  zp_range_classify #(
    .ADDR_W(ADDR_W), .INC_LO(INC_LO), .INC_HI(INC_HI),
    .DEC_LO(DEC_LO), .DEC_HI(DEC_HI)
  ) u_cls (
    .idx_i (idx_addr_i),
    .mode_o(mode_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      mode_q <= UPD_BYPASS;
    end else if (accept) begin
      idx_q  <= idx_addr_i;
      mode_q <= mode_new;
    end
  end

  zp_seq_fsm u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .mode_new_i(mode_new),
    .mode_i    (mode_q),
    .accept_o  (accept),
    .rd_o      (mem_re_o),
    .wr_o      (mem_we_o),
    .hi_sel_o  (hi_sel),
    .cap_lo_o  (cap_lo),
    .cap_hi_o  (cap_hi),
    .done_o    (done_o),
    .busy_o    (busy_o)
  );

  zp_ptr_regs #(.DATA_W(DATA_W)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (accept),
    .cap_lo_i(cap_lo),
    .cap_hi_i(cap_hi),
    .rdata_i (mem_rdata_i),
    .mode_i  (mode_q),
    .ptr_o   (ptr),
    .nxt_o   (nxt)
  );

  assign mem_addr_o  = hi_sel ? idx_q + ADDR_W'(1) : idx_q;
  assign mem_wdata_o = hi_sel ? nxt[PTR_W-1:DATA_W] : nxt[DATA_W-1:0];
  assign ea_o        = ptr;
endmodule

// File: rtl/zp_auto_index_chk.sv
module zp_auto_index_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned INC_LO = 2,
  parameter int unsigned DEC_HI = 127
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] idx_addr_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              mem_re_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  logic [ADDR_W-1:0] idx_c;
  logic              keep_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 idx_c <= '0;
    else if (start_i && !busy_o) idx_c <= idx_addr_i;
  end

  assign keep_c = (idx_c != '0) &&
                  ((idx_c < ADDR_W'(INC_LO)) || (idx_c > ADDR_W'(DEC_HI)));

  a_r9_no_rw_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  a_r2_bypass_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && idx_c == '0) |-> (!mem_re_o && !mem_we_o));

  a_r6_keep_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && keep_c) |-> !mem_we_o);

  a_r7_hi_after_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_addr_o == idx_c + ADDR_W'(1)) |->
      ($past(mem_we_o) && $past(mem_addr_o) == idx_c));

  a_r3_read_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && mem_addr_o == idx_c + ADDR_W'(1)) |->
      ($past(mem_re_o) && $past(mem_addr_o) == idx_c));

  a_r8_addr_follows_accepted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o || mem_we_o) |->
      (mem_addr_o == idx_c || mem_addr_o == idx_c + ADDR_W'(1)));
endmodule

bind zp_auto_index zp_auto_index_chk #(
  .ADDR_W(ADDR_W), .INC_LO(INC_LO), .DEC_HI(DEC_HI)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .idx_addr_i(idx_addr_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .mem_re_o  (mem_re_o),
  .mem_we_o  (mem_we_o),
  .mem_addr_o(mem_addr_o)
);

// File: tb/zp_auto_index_tb.sv
module zp_auto_index_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  idx_in = '0;
  logic        busy, done, mem_re, mem_we;
  logic [15:0] ea;
  logic [7:0]  mem_addr, mem_wdata;
  logic [7:0]  mem_rdata = '0;

  int n_chk = 0, n_bad = 0, done_cnt = 0, rd_cnt = 0, wr_cnt = 0;
  logic [7:0] zp [256];
  logic [7:0] wr_log [$];

  typedef struct {
    logic [7:0]  idx;
    logic [15:0] ea;
    int          nrd;
    int          nwr;
    int          rd_base;
    int          wr_base;
    string       tag;
  } item_t;
  item_t sb_q [$];

  always #5 clk = ~clk;

  zp_auto_index u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .idx_addr_i(idx_in),
    .busy_o(busy), .done_o(done), .ea_o(ea),
    .mem_re_o(mem_re), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  // memory model, one-cycle read latency (R10)
  always @(posedge clk) begin
    if (mem_re) begin
      mem_rdata <= zp[mem_addr];
      rd_cnt    <= rd_cnt + 1;
    end
    if (mem_we) begin
      zp[mem_addr] <= mem_wdata;
      wr_cnt       <= wr_cnt + 1;
      wr_log.push_back(mem_addr);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pop scoreboard on done
  always @(negedge clk) begin
    if (rst_n && done) begin
      done_cnt++;
      if (sb_q.size() == 0) begin
        check(1'b0, "R8 unexpected done", 1, 0);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        check(ea == it.ea, {it.tag, " ea"}, ea, it.ea);
        check(rd_cnt - it.rd_base == it.nrd, {it.tag, " reads"}, rd_cnt - it.rd_base, it.nrd);
        check(wr_cnt - it.wr_base == it.nwr, {it.tag, " writes"}, wr_cnt - it.wr_base, it.nwr);
        if (it.nwr == 2 && wr_cnt - it.wr_base == 2) begin
          check(wr_log[it.wr_base] == it.idx, "R7 first write low", wr_log[it.wr_base], it.idx);
          check(wr_log[it.wr_base+1] == it.idx + 8'd1, "R7 second write high",
                wr_log[it.wr_base+1], it.idx + 8'd1);
        end
      end
    end
  end

  task automatic wait_idle(input string tag);
    for (int i = 0; i < 40 && busy; i++) @(negedge clk);
    check(!busy, {tag, " idle after request"}, busy, 0);
  endtask

  // driver: compute expectation, push, issue request
  task automatic run_case(input logic [7:0] idx, input bit do_init,
                          input logic [15:0] init, input string tag);
    item_t it;
    logic [15:0] p, nxt;
    logic [7:0] ah;
    ah = idx + 8'd1;
    if (do_init && idx != 8'h00) begin
      zp[idx] = init[7:0];
      zp[ah]  = init[15:8];
    end
    p = (idx == 8'h00) ? 16'h0000 : {zp[ah], zp[idx]};
    if (idx >= 8'h02 && idx <= 8'h3f)      nxt = p + 16'd1;
    else if (idx >= 8'h40 && idx <= 8'h7f) nxt = p - 16'd1;
    else                                   nxt = p;
    it.idx = idx; it.ea = p; it.tag = tag;
    it.nrd = (idx == 8'h00) ? 0 : 2;
    it.nwr = (nxt != p) ? 2 : 0;
    it.rd_base = rd_cnt; it.wr_base = wr_cnt;
    sb_q.push_back(it);
    @(negedge clk);
    idx_in = idx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle(tag);
    check(sb_q.size() == 0, {tag, " scoreboard drained"}, sb_q.size(), 0);
    if (idx != 8'h00) begin
      check(zp[idx] == nxt[7:0], {tag, " stored low"}, zp[idx], nxt[7:0]);
      check(zp[ah] == nxt[15:8], {tag, " stored high"}, zp[ah], nxt[15:8]);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) zp[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    check(!done && !busy && !mem_re && !mem_we, "R1 in reset", {done, busy, mem_re, mem_we}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!done && !busy && !mem_re && !mem_we, "R1 after reset", {done, busy, mem_re, mem_we}, 0);

    run_case(8'h00, 1'b0, 16'h0000, "R2 no index");
    run_case(8'h02, 1'b1, 16'h1234, "R4 inc low edge");
    run_case(8'h3f, 1'b1, 16'hffff, "R4 inc wrap top edge");
    run_case(8'h40, 1'b1, 16'h0000, "R5 dec wrap low edge");
    run_case(8'h7f, 1'b1, 16'h8000, "R5 dec top edge");
    run_case(8'h01, 1'b1, 16'hbeef, "R6 keep 0x01");
    run_case(8'h80, 1'b1, 16'hcafe, "R6 keep 0x80");
    run_case(8'hff, 1'b1, 16'h5aa5, "R3 R6 keep 0xff wraps to 0x00");
    run_case(8'h10, 1'b1, 16'h00ff, "R4 carry into high");
    run_case(8'h10, 1'b0, 16'h0000, "R3 R4 second use post-modify");
    run_case(8'h50, 1'b1, 16'h0100, "R5 borrow from high");

    // R8: second strobe while busy is ignored
    begin
      int dc;
      logic [7:0] lo20, hi20;
      zp[8'h20] = 8'h11; zp[8'h21] = 8'h22;
      lo20 = zp[8'h20]; hi20 = zp[8'h21];
      dc = done_cnt;
      fork
        run_case(8'h30, 1'b1, 16'h7000, "R8 accepted request");
        begin
          repeat (3) @(negedge clk);
          idx_in = 8'h20; start = 1'b1;
          @(negedge clk);
          start = 1'b0;
        end
      join
      repeat (4) @(negedge clk);
      check(done_cnt - dc == 1, "R8 single done", done_cnt - dc, 1);
      check(zp[8'h20] == lo20 && zp[8'h21] == hi20, "R8 ignored pointer untouched",
            {zp[8'h21], zp[8'h20]}, {hi20, lo20});
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule